// File: doc/BRIEF.md
# Pixel Output Watermark and Sync Monitor

This block sits beside the pixel output stage of a display controller. It watches the fill level of the output pixel buffer and compares it against two programmable watermarks. When the level rises above the upper watermark, it drops a clock enable so the upstream datapath pauses. When the level falls below the lower watermark while pixels are being shown, it latches an underrun status flag.

The block also counts the lines of each frame. It latches an early-warning flag a programmable number of lines before the line on which vertical sync begins. Finally, it passes the horizontal, vertical and composite sync signals through a registered stage that can invert each one on its own, so that each sync can be driven active high or active low.

Software configures the block and reads it back through a small word-wide register port with three addresses. The status flags stay set until software writes a 1 to clear them.

Top module: `pixout_wm_mon`

## Requirements
- R1: After reset, address 0 reads 0x0000780A (line threshold 0, upper watermark 120, lower watermark 10), address 1 reads 0, address 2 reads 0, and `dp_ce` is 1.
- R2: Address 0 holds the line threshold in bits [25:16], the upper watermark in bits [15:8] and the lower watermark in bits [7:0]. Bits [31:26] read as 0. Writes update all three fields in one step.
- R3: `dp_ce` is 0 in the same cycle that `fill_level` is strictly above the upper watermark. It is 1 whenever the level is at or below that watermark, with no hysteresis. This holds for levels above 255.
- R4: `sts_underrun` becomes 1 one clock after a cycle in which `pix_vld`, `active` and (`fill_level` < lower watermark) are all true. A level equal to the watermark does not set it. A low level while `active` is 0 does not set it.
- R5: `sts_underrun` stays set until software writes address 2 with bit 0 = 1. Writing bit 0 = 0 has no effect. A new set condition in the same cycle as the clear keeps the flag at 1.
- R6: `frame_start` starts line 0, and each `line_start` advances the line index by one. `sts_early` becomes 1 at the clock that starts the line whose index equals `vs_line` minus the line threshold.
- R7: With a line threshold of 0, `sts_early` sets on line `vs_line` itself. With a threshold equal to `vs_line`, it sets at `frame_start`. With a threshold above `vs_line`, it never sets in that frame.
- R8: `sts_early` stays set until software writes address 2 with bit 1 = 1.
- R9: Address 1 bit 2 inverts `hs_in`, bit 1 inverts `vs_in`, and bit 0 inverts `cs_in`. Each output equals its input XOR its invert bit, delayed by exactly one clock.
- R10: Address 2 reads `sts_early` in bit 1 and `sts_underrun` in bit 0. All other bits read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 thresholds, 1 polarity, 2 status) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from `reg_addr` |
| fill_level | input | LVL_W | Output buffer fill level in pixels |
| pix_vld | input | 1 | A pixel is taken from the buffer this cycle |
| active | input | 1 | Output is in the active display region |
| frame_start | input | 1 | Strobe for the start of line 0 of a frame |
| line_start | input | 1 | Strobe for the start of each further line |
| vs_line | input | LINE_W | Line index on which vertical sync begins |
| hs_in | input | 1 | Raw horizontal sync |
| vs_in | input | 1 | Raw vertical sync |
| cs_in | input | 1 | Raw composite sync |
| dp_ce | output | 1 | Datapath clock enable (0 = suspend) |
| sts_underrun | output | 1 | Sticky underrun flag |
| sts_early | output | 1 | Sticky lines-before-vsync flag |
| hs_out | output | 1 | Polarity-adjusted horizontal sync |
| vs_out | output | 1 | Polarity-adjusted vertical sync |
| cs_out | output | 1 | Polarity-adjusted composite sync |

## Verification
The bench builds the block with its default parameters: a 9-bit fill level and a 10-bit line counter. The 9-bit level lets the bench drive levels such as 300, which lie above any value the 8-bit upper watermark can hold, so the stall can be checked past the field's range. The 10-bit counter together with short frames of about 30 lines reaches every early-warning corner: a target on line 0, a target in the middle of the frame, a target on the sync line itself, and a threshold larger than the sync line.

// File: rtl/pixout_wm_mon.sv
module pixout_wm_mon #(
  parameter int LVL_W  = 9,
  parameter int LINE_W = 10,
  parameter int HI_RST = 120,
  parameter int LO_RST = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [1:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [LVL_W-1:0]  fill_level,
  input  logic              pix_vld,
  input  logic              active,
  input  logic              frame_start,
  input  logic              line_start,
  input  logic [LINE_W-1:0] vs_line,
  input  logic              hs_in,
  input  logic              vs_in,
  input  logic              cs_in,
  output logic              dp_ce,
  output logic              sts_underrun,
  output logic              sts_early,
  output logic              hs_out,
  output logic              vs_out,
  output logic              cs_out
);
  localparam int CW = (LVL_W > 8 ? LVL_W : 8);
  localparam int AW = (LINE_W > 10 ? LINE_W : 10) + 1;

  logic [9:0]        thr_lines;
  logic [7:0]        thr_hi, thr_lo;
  logic              inv_hs, inv_vs, inv_cs;
  logic [LINE_W-1:0] line_cnt, cnt_nxt;
  logic [AW-1:0]     vs_x, thr_x, cnt_x, tgt;
  logic [CW-1:0]     lvl_x;
  logic              wr_thr, wr_pol, wr_sts, urun_set, early_hit, adv;

  assign wr_thr = reg_we && reg_addr == 2'd0;
  assign wr_pol = reg_we && reg_addr == 2'd1;
  assign wr_sts = reg_we && reg_addr == 2'd2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thr_lines <= '0;
      thr_hi    <= 8'(HI_RST);
      thr_lo    <= 8'(LO_RST);
      inv_hs    <= 1'b0;
      inv_vs    <= 1'b0;
      inv_cs    <= 1'b0;
    end else begin
      if (wr_thr) begin
        thr_lines <= reg_wdata[25:16];
        thr_hi    <= reg_wdata[15:8];
        thr_lo    <= reg_wdata[7:0];
      end
      if (wr_pol) begin
        inv_hs <= reg_wdata[2];
        inv_vs <= reg_wdata[1];
        inv_cs <= reg_wdata[0];
      end
    end
  end

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = {6'b0, thr_lines, thr_hi, thr_lo};
      2'd1:    reg_rdata = {29'b0, inv_hs, inv_vs, inv_cs};
      2'd2:    reg_rdata = {30'b0, sts_early, sts_underrun};
      default: reg_rdata = '0;
    endcase
  end

  assign lvl_x    = CW'(fill_level);
  assign dp_ce    = !(lvl_x > CW'(thr_hi));
  assign urun_set = pix_vld && active && (lvl_x < CW'(thr_lo));

  assign adv     = frame_start || line_start;
  assign cnt_nxt = frame_start ? '0 : line_cnt + 1'b1;
  assign vs_x    = AW'(vs_line);
  assign thr_x   = AW'(thr_lines);
  assign cnt_x   = AW'(cnt_nxt);
  assign tgt     = vs_x - thr_x;
  assign early_hit = adv && (vs_x >= thr_x) && (cnt_x == tgt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_cnt     <= '0;
      sts_underrun <= 1'b0;
      sts_early    <= 1'b0;
      hs_out       <= 1'b0;
      vs_out       <= 1'b0;
      cs_out       <= 1'b0;
    end else begin
      if (adv) line_cnt <= cnt_nxt;
      sts_underrun <= urun_set  || (sts_underrun && !(wr_sts && reg_wdata[0]));
      sts_early    <= early_hit || (sts_early    && !(wr_sts && reg_wdata[1]));
      hs_out <= hs_in ^ inv_hs;
      vs_out <= vs_in ^ inv_vs;
      cs_out <= cs_in ^ inv_cs;
    end
  end
endmodule

module pixout_wm_mon_chk #(
  parameter int LVL_W = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_we,
  input logic [1:0]       reg_addr,
  input logic [31:0]      reg_wdata,
  input logic [LVL_W-1:0] fill_level,
  input logic             pix_vld,
  input logic             active,
  input logic [7:0]       thr_lo,
  input logic             inv_hs,
  input logic             inv_vs,
  input logic             inv_cs,
  input logic             hs_in,
  input logic             vs_in,
  input logic             cs_in,
  input logic             hs_out,
  input logic             vs_out,
  input logic             cs_out,
  input logic             dp_ce,
  input logic             sts_underrun,
  input logic             sts_early
);
  localparam int CW = (LVL_W > 8 ? LVL_W : 8);
  logic low_now, clr_u, clr_e;
  assign low_now = pix_vld && active && (CW'(fill_level) < CW'(thr_lo));
  assign clr_u   = reg_we && reg_addr == 2'd2 && reg_wdata[0];
  assign clr_e   = reg_we && reg_addr == 2'd2 && reg_wdata[1];

  // R9
  sync_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (hs_out == ($past(hs_in) ^ $past(inv_hs))) &&
                     (vs_out == ($past(vs_in) ^ $past(inv_vs))) &&
                     (cs_out == ($past(cs_in) ^ $past(inv_cs))));
  // R4
  urun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(low_now)) |-> sts_underrun);
  // R4
  urun_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(sts_underrun) && !$past(active)) |-> !sts_underrun);
  // R5
  urun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(sts_underrun) && !$past(clr_u)) |-> sts_underrun);
  // R8
  early_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(sts_early) && !$past(clr_e)) |-> sts_early);
  // R3
  ce_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_level == '0) |-> dp_ce);
endmodule

bind pixout_wm_mon pixout_wm_mon_chk #(.LVL_W(LVL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .fill_level(fill_level), .pix_vld(pix_vld),
  .active(active), .thr_lo(thr_lo), .inv_hs(inv_hs), .inv_vs(inv_vs),
  .inv_cs(inv_cs), .hs_in(hs_in), .vs_in(vs_in), .cs_in(cs_in),
  .hs_out(hs_out), .vs_out(vs_out), .cs_out(cs_out), .dp_ce(dp_ce),
  .sts_underrun(sts_underrun), .sts_early(sts_early)
);

// File: tb/pixout_wm_mon_bench.sv
module pixout_wm_mon_bench;
  localparam int LVL_W = 9, LINE_W = 10;
  logic clk = 0, rst_n = 0;
  logic reg_we = 0;
  logic [1:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic [LVL_W-1:0] fill_level = 0;
  logic pix_vld = 0, active = 0, frame_start = 0, line_start = 0;
  logic [LINE_W-1:0] vs_line = 0;
  logic hs_in = 0, vs_in = 0, cs_in = 0;
  logic dp_ce, sts_underrun, sts_early, hs_out, vs_out, cs_out;
  int total = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pixout_wm_mon #(.LVL_W(LVL_W), .LINE_W(LINE_W)) u_pixout_wm_mon (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .fill_level(fill_level),
    .pix_vld(pix_vld), .active(active), .frame_start(frame_start),
    .line_start(line_start), .vs_line(vs_line), .hs_in(hs_in), .vs_in(vs_in),
    .cs_in(cs_in), .dp_ce(dp_ce), .sts_underrun(sts_underrun),
    .sts_early(sts_early), .hs_out(hs_out), .vs_out(vs_out), .cs_out(cs_out));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0; reg_wdata = 0;
  endtask

  task automatic rd_check(string req, logic [1:0] a, logic [31:0] exp);
    reg_addr = a; #1; check(req, reg_rdata, exp);
  endtask

  task automatic t_reset();
    rd_check("R1 thr reset", 2'd0, 32'h0000_780A);
    rd_check("R1 pol reset", 2'd1, 32'h0);
    rd_check("R1 sts reset", 2'd2, 32'h0);
    check("R1 ce reset", dp_ce, 1);
  endtask

  task automatic t_regs();
    wr(2'd0, 32'hFFFF_FFFF);
    rd_check("R2 unused bits zero", 2'd0, 32'h03FF_FFFF);
    wr(2'd0, {6'b0, 10'd300, 8'd77, 8'd33});
    rd_check("R2 field layout", 2'd0, {6'b0, 10'd300, 8'd77, 8'd33});
  endtask

  task automatic t_ce();
    wr(2'd0, {6'b0, 10'd0, 8'd50, 8'd10});
    @(negedge clk); fill_level = 50; #1; check("R3 equal keeps ce", dp_ce, 1);
    fill_level = 51; #1; check("R3 above drops ce", dp_ce, 0);
    fill_level = 300; #1; check("R3 level above 255", dp_ce, 0);
    fill_level = 0; #1; check("R3 ce restored", dp_ce, 1);
  endtask

  task automatic t_underrun();
    wr(2'd0, {6'b0, 10'd0, 8'd120, 8'd10});
    @(negedge clk); active = 1; pix_vld = 1; fill_level = 10;
    @(negedge clk); check("R4 equal no underrun", sts_underrun, 0);
    active = 0; fill_level = 0;
    @(negedge clk); check("R4 inactive no underrun", sts_underrun, 0);
    active = 1; fill_level = 9;
    @(negedge clk); check("R4 underrun set", sts_underrun, 1);
    active = 0; pix_vld = 0; fill_level = 60;
    wr(2'd2, 32'h0);
    check("R5 write 0 keeps flag", sts_underrun, 1);
    rd_check("R10 status read", 2'd2, 32'h1);
    wr(2'd2, 32'h1);
    check("R5 write 1 clears", sts_underrun, 0);
    @(negedge clk); active = 1; pix_vld = 1; fill_level = 0;
    reg_we = 1; reg_addr = 2'd2; reg_wdata = 32'h1;
    @(negedge clk); reg_we = 0; active = 0; pix_vld = 0; fill_level = 60;
    check("R5 set wins over clear", sts_underrun, 1);
    wr(2'd2, 32'h1);
  endtask

  task automatic frame(string req, int vs, int thr, int exp_line);
    int first = -1;
    wr(2'd0, {6'b0, 10'(thr), 8'd120, 8'd10});
    wr(2'd2, 32'h3);
    vs_line = LINE_W'(vs);
    @(negedge clk); frame_start = 1;
    @(negedge clk); frame_start = 0;
    if (sts_early) first = 0;
    for (int k = 1; k <= 30; k++) begin
      line_start = 1;
      @(negedge clk); line_start = 0;
      if (sts_early && first < 0) first = k;
      @(negedge clk);
    end
    check(req, 32'(first), 32'(exp_line));
  endtask

  task automatic t_early();
    frame("R6 early on vs-thr line", 20, 5, 15);
    rd_check("R10 early bit", 2'd2, 32'h2);
    wr(2'd2, 32'h1);
    check("R8 bit0 keeps early", sts_early, 1);
    wr(2'd2, 32'h2);
    check("R8 bit1 clears early", sts_early, 0);
    frame("R7 thr zero on vsync line", 20, 0, 20);
    frame("R7 thr equals vs line", 20, 20, 0);
    frame("R7 thr beyond vs line", 20, 25, -1);
  endtask

  task automatic t_pol();
    wr(2'd1, 32'h5);
    rd_check("R9 pol readback", 2'd1, 32'h5);
    @(negedge clk); hs_in = 0; vs_in = 1; cs_in = 0;
    @(negedge clk);
    check("R9 hs inverted", hs_out, 1);
    check("R9 vs passed", vs_out, 1);
    check("R9 cs inverted", cs_out, 1);
    hs_in = 1; #1;
    check("R9 one-cycle latency", hs_out, 1);
    @(negedge clk); check("R9 hs after edge", hs_out, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_ce();
    t_underrun();
    t_early();
    t_pol();
    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule